// File: doc/BRIEF.md
# Forty-Column Text Scanline Renderer

This block renders one scanline of a character-based video display in which each text row carries 40 character cells, each six pixels wide. A pulse on `line_start` tells it which raw scanline is next. It then reads a name byte for each cell from video memory, followed by the pattern byte for that character, and writes colour indices for the line into a 256-entry line buffer. A downstream scan doubler reads that buffer back, and so does the sprite logic.

The forty cells cover only 240 of the 256 buffer positions. The renderer therefore writes the remaining 16 positions with the blank index, so that data left over from an earlier line is never shown. The picture is shifted 16 scanlines down. A line is drawn from video memory only when the display is enabled and the raw scanline lies inside the 192-line window that starts at line 16. Every other line is filled with the background colour and makes no memory reads.

Top module: `text40_line_renderer`

## Requirements
- R1: While `rst_n` is low, and when no line is in progress after reset, `rd_req` and `lb_we` are 0.
- R2: For an active line, the name-byte read of cell c (0..39) uses address `name_base + row*40 + c` modulo 2^14, where row = (vcount-16)/8. Cells are fetched in increasing order, and each name read comes before that cell's pattern read.
- R3: The pattern read for a cell uses address `pat_base + ch*8 + ((vcount-16) mod 8)` modulo 2^14, where ch is the name byte returned for that cell.
- R4: On an active line, pixel x = 6c+i (i in 0..5) takes pattern-byte bit 7-i. A 1 gives the foreground colour `colours[7:4]` and a 0 gives the background colour `colours[3:0]`.
- R5: Line-buffer positions 240..255 are written with colour index 0 on every line.
- R6: When `disp_en` is 0 at `line_start`, positions 0..239 are written with `colours[3:0]` and no video-memory read is made.
- R7: A line whose `vcount` is below 16 or at least 208 behaves as in R6. Line 16 shows text row 0, fine line 0, and line 207 shows row 23, fine line 7.
- R8: Every line writes each buffer address 0..255 exactly once, in increasing order, and then stops writing.
- R9: Once `rd_req` is raised, it and `rd_addr` stay unchanged until a cycle in which `rd_ack` is 1. `rd_data` is taken in that cycle.
- R10: A `line_start` pulse that arrives while a line is being rendered is ignored. It causes no extra writes and no change to the line in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that starts rendering a line |
| vcount | input | 9 | Raw scanline number, sampled at line_start |
| disp_en | input | 1 | Display enable, sampled at line_start |
| colours | input | 8 | Foreground colour [7:4], background colour [3:0] |
| name_base | input | 14 | Name table base address |
| pat_base | input | 14 | Pattern table base address |
| rd_req | output | 1 | Video-memory read request |
| rd_addr | output | 14 | Video-memory read address |
| rd_ack | input | 1 | Read acknowledge, with rd_data valid |
| rd_data | input | 8 | Video-memory read data |
| lb_we | output | 1 | Line-buffer write strobe |
| lb_addr | output | 8 | Line-buffer pixel position |
| lb_data | output | 4 | Line-buffer colour index |

## Verification
The hardest situation to reach is a `line_start` that collides with a render in progress, while the memory acknowledges slowly and `vcount` changes under the renderer. The bench starts a line, waits for a mid-line cell, then pulses `line_start` with a different scanline. It then checks that the buffer still holds the first line and that exactly 256 writes occurred. The edges of the vertical window, lines 15, 16, 207 and 208, are driven with both zero-wait and multi-cycle acknowledge latencies, so that both the fetch order and the held request are exercised.

// File: rtl/text40_pkg.sv
// Shared types for the forty-column text renderer.
// Assumes: a single clock domain; states are encoded by the synthesis tool.
package text40_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a line start
        ST_NAME,   // name-byte read outstanding
        ST_PAT,    // pattern-byte read outstanding
        ST_CELL,   // emitting the pixels of one cell
        ST_FILL,   // background fill of the active width
        ST_EDGE    // blanking the unused right edge
    } rstate_t;
endpackage

// File: rtl/t40_seq.sv
// Line sequencer: latches the line context at line_start, walks the cells,
// issues name/pattern reads and steps the line-buffer position.
// Assumes: rd_data is valid in the cycle rd_ack is high; line_start is
// honoured only while idle.
module t40_seq
    import text40_pkg::*;
#(
    parameter int VC_W   = 9,
    parameter int COLS   = 40,
    parameter int CELL_W = 6,
    parameter int LINE_W = 256,
    parameter int ROWS   = 24,
    parameter int CHAR_H = 8,
    parameter int V_OFF  = 16,
    parameter int DATA_W = 8,
    localparam int ACT_W  = COLS * CELL_W,
    localparam int X_W    = $clog2(LINE_W),
    localparam int COL_W  = $clog2(COLS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int FINE_W = $clog2(CHAR_H),
    localparam int SUB_W  = $clog2(CELL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [VC_W-1:0]   vcount,
    input  logic              disp_en,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic              sel_pat,
    output logic              pat_load,
    output logic              px_valid,
    output logic              fill_bg,
    output logic              edge_blank,
    output logic [ROW_W-1:0]  row,
    output logic [FINE_W-1:0] fine,
    output logic [COL_W-1:0]  col,
    output logic [DATA_W-1:0] char_q,
    output logic [X_W-1:0]    x
);
    rstate_t          st;
    logic [SUB_W-1:0] sub;
    logic [VC_W-1:0]  vrel;
    logic             in_window;

    // Position of the line inside the shifted display window.
    always_comb begin
        vrel      = vcount - VC_W'(V_OFF);
        in_window = (vcount >= VC_W'(V_OFF)) &&
                    (vcount <  VC_W'(V_OFF + ROWS * CHAR_H));
    end

    // Decoded strobes for the fetch port, serialiser and output stage.
    always_comb begin
        rd_req     = (st == ST_NAME) || (st == ST_PAT);
        sel_pat    = (st == ST_PAT);
        pat_load   = (st == ST_PAT) && rd_ack;
        px_valid   = (st == ST_CELL);
        fill_bg    = (st == ST_FILL);
        edge_blank = (st == ST_EDGE);
    end

    // State, cell and pixel counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            sub    <= '0;
            col    <= '0;
            x      <= '0;
            row    <= '0;
            fine   <= '0;
            char_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (line_start) begin
                    x    <= '0;
                    col  <= '0;
                    row  <= ROW_W'(vrel / VC_W'(CHAR_H));
                    fine <= FINE_W'(vrel % VC_W'(CHAR_H));
                    st   <= (disp_en && in_window) ? ST_NAME : ST_FILL;
                end
                ST_NAME: if (rd_ack) begin
                    char_q <= rd_data;
                    st     <= ST_PAT;
                end
                ST_PAT: if (rd_ack) begin
                    sub <= '0;
                    st  <= ST_CELL;
                end
                ST_CELL: begin
                    x   <= x + 1'b1;
                    sub <= sub + 1'b1;
                    if (sub == SUB_W'(CELL_W - 1)) begin
                        if (col == COL_W'(COLS - 1)) begin
                            st <= ST_EDGE;
                        end else begin
                            col <= col + 1'b1;
                            st  <= ST_NAME;
                        end
                    end
                end
                ST_FILL: begin
                    x <= x + 1'b1;
                    if (x == X_W'(ACT_W - 1)) st <= ST_EDGE;
                end
                ST_EDGE: begin
                    x <= x + 1'b1;
                    if (x == X_W'(LINE_W - 1)) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/t40_addr_gen.sv
// Address generator: forms the name-table and pattern-table read addresses
// and selects the one the sequencer is fetching.
// Assumes: the table offsets wrap modulo the address space.
module t40_addr_gen #(
    parameter int VA_W   = 14,
    parameter int COLS   = 40,
    parameter int ROWS   = 24,
    parameter int CHAR_H = 8,
    parameter int DATA_W = 8,
    localparam int COL_W  = $clog2(COLS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int FINE_W = $clog2(CHAR_H)
) (
    input  logic [VA_W-1:0]   name_base,
    input  logic [VA_W-1:0]   pat_base,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [FINE_W-1:0] fine,
    input  logic [DATA_W-1:0] char_q,
    input  logic              sel_pat,
    output logic [VA_W-1:0]   rd_addr
);
    logic [VA_W-1:0] name_addr;
    logic [VA_W-1:0] pat_addr;

    // Table offsets and the fetch address multiplexer.
    always_comb begin
        name_addr = name_base + VA_W'(row) * VA_W'(COLS) + VA_W'(col);
        pat_addr  = pat_base + VA_W'(char_q) * VA_W'(CHAR_H) + VA_W'(fine);
        rd_addr   = sel_pat ? pat_addr : name_addr;
    end
endmodule

// File: rtl/t40_serializer.sv
// Cell serialiser: holds the visible pattern bits of one cell and presents
// them most significant first as a colour index.
// Assumes: load and shift never occur in the same cycle.
module t40_serializer #(
    parameter int CELL_W = 6,
    parameter int COL_BW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [CELL_W-1:0] bits_in,
    input  logic [COL_BW-1:0] fg,
    input  logic [COL_BW-1:0] bg,
    output logic [COL_BW-1:0] pix
);
    logic [CELL_W-1:0] shreg;

    // Pattern shift register, loaded per cell and shifted per pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)     shreg <= '0;
        else if (load)  shreg <= bits_in;
        else if (shift) shreg <= shreg << 1;
    end

    // Colour selection for the bit in the leading position.
    always_comb pix = shreg[CELL_W-1] ? fg : bg;
endmodule

// File: rtl/text40_line_renderer.sv
// Forty-column text scanline renderer: top level. Joins the sequencer,
// address generator and serialiser, and registers the line-buffer writes.
// Assumes: one line is rendered per line_start; the buffer write port
// accepts one write per cycle.
module text40_line_renderer #(
    parameter int VA_W   = 14,
    parameter int VC_W   = 9,
    parameter int DATA_W = 8,
    parameter int COL_BW = 4,
    parameter int COLS   = 40,
    parameter int CELL_W = 6,
    parameter int LINE_W = 256,
    parameter int ROWS   = 24,
    parameter int CHAR_H = 8,
    parameter int V_OFF  = 16,
    localparam int X_W    = $clog2(LINE_W),
    localparam int COL_W  = $clog2(COLS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int FINE_W = $clog2(CHAR_H)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic [VC_W-1:0]     vcount,
    input  logic                disp_en,
    input  logic [2*COL_BW-1:0] colours,
    input  logic [VA_W-1:0]     name_base,
    input  logic [VA_W-1:0]     pat_base,
    output logic                rd_req,
    output logic [VA_W-1:0]     rd_addr,
    input  logic                rd_ack,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                lb_we,
    output logic [X_W-1:0]      lb_addr,
    output logic [COL_BW-1:0]   lb_data
);
    logic              sel_pat, pat_load, px_valid, fill_bg, edge_blank;
    logic [ROW_W-1:0]  row;
    logic [FINE_W-1:0] fine;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] char_q;
    logic [X_W-1:0]    x;
    logic [COL_BW-1:0] fg, bg, pix;

    // Colour register split into its two fields.
    always_comb begin
        fg = colours[2*COL_BW-1:COL_BW];
        bg = colours[COL_BW-1:0];
    end

    t40_seq #(
        .VC_W(VC_W), .COLS(COLS), .CELL_W(CELL_W), .LINE_W(LINE_W),
        .ROWS(ROWS), .CHAR_H(CHAR_H), .V_OFF(V_OFF), .DATA_W(DATA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .vcount(vcount),
        .disp_en(disp_en), .rd_ack(rd_ack), .rd_data(rd_data),
        .rd_req(rd_req), .sel_pat(sel_pat), .pat_load(pat_load),
        .px_valid(px_valid), .fill_bg(fill_bg), .edge_blank(edge_blank),
        .row(row), .fine(fine), .col(col), .char_q(char_q), .x(x)
    );

    t40_addr_gen #(
        .VA_W(VA_W), .COLS(COLS), .ROWS(ROWS), .CHAR_H(CHAR_H), .DATA_W(DATA_W)
    ) u_addr (
        .name_base(name_base), .pat_base(pat_base), .row(row), .col(col),
        .fine(fine), .char_q(char_q), .sel_pat(sel_pat), .rd_addr(rd_addr)
    );

    t40_serializer #(.CELL_W(CELL_W), .COL_BW(COL_BW)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(pat_load), .shift(px_valid),
        .bits_in(rd_data[DATA_W-1 -: CELL_W]), .fg(fg), .bg(bg), .pix(pix)
    );

    // Registered line-buffer write: cell pixel, background fill or blank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lb_we   <= 1'b0;
            lb_addr <= '0;
            lb_data <= '0;
        end else begin
            lb_we   <= px_valid | fill_bg | edge_blank;
            lb_addr <= x;
            lb_data <= edge_blank ? '0 : (fill_bg ? bg : pix);
        end
    end
endmodule

// File: rtl/t40_chk.sv
// Protocol and ordering checker for the text renderer, bound to the top.
// Assumes: the same clock and reset as the renderer.
module t40_chk #(
    parameter int VA_W   = 14,
    parameter int X_W    = 8,
    parameter int COL_BW = 4,
    parameter int LINE_W = 256,
    parameter int ACT_W  = 240
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [VA_W-1:0]   rd_addr,
    input logic              lb_we,
    input logic [X_W-1:0]    lb_addr,
    input logic [COL_BW-1:0] lb_data
);
    logic [X_W-1:0] exp_addr;

    // Tracks the buffer position the next write must use.
    always_ff @(posedge clk) begin
        if (!rst_n) exp_addr <= '0;
        else if (lb_we)
            exp_addr <= (exp_addr == X_W'(LINE_W - 1)) ? '0 : exp_addr + 1'b1;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req);
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> $stable(rd_addr));
    // R5
    edge_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_we && (lb_addr >= X_W'(ACT_W)) |-> lb_data == '0);
    // R8
    write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_we |-> lb_addr == exp_addr);
endmodule

bind text40_line_renderer t40_chk #(
    .VA_W(VA_W), .X_W(X_W), .COL_BW(COL_BW), .LINE_W(LINE_W),
    .ACT_W(COLS * CELL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_addr(rd_addr), .lb_we(lb_we), .lb_addr(lb_addr), .lb_data(lb_data)
);

// File: tb/sim_text40_line_renderer.sv
`timescale 1ns/1ps
module sim_text40_line_renderer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [8:0]  vcount = '0;
    logic        disp_en = 1'b0;
    logic [7:0]  colours = '0;
    logic [13:0] name_base = '0, pat_base = '0;
    logic        rd_req, rd_ack = 1'b0;
    logic [13:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        lb_we;
    logic [7:0]  lb_addr;
    logic [3:0]  lb_data;

    int vectors = 0, fails = 0;
    int seed = 0, lat = 0, wcnt = 0;
    int nreads = 0, nwr = 0, order_err = 0, hold_err = 0;
    logic [13:0] reads [0:127];
    logic [3:0]  pix [0:255];
    logic        hold_pend = 1'b0;
    logic [13:0] hold_addr = '0;

    always #2.5 clk = ~clk;

    text40_line_renderer u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .vcount(vcount),
        .disp_en(disp_en), .colours(colours), .name_base(name_base),
        .pat_base(pat_base), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .lb_we(lb_we),
        .lb_addr(lb_addr), .lb_data(lb_data)
    );

    // Video memory contents: a computed byte per address.
    function automatic logic [7:0] vb(input logic [13:0] a);
        int t;
        t = int'(a) * 29 + (int'(a) >> 4) + seed;
        return t[7:0];
    endfunction

    // Memory model with configurable wait, plus request-hold monitor.
    always @(negedge clk) begin
        logic grant;
        grant = 1'b0;
        if (!rst_n) begin
            rd_ack <= 1'b0;
            wcnt = 0;
            hold_pend = 1'b0;
        end else begin
            if (hold_pend && (!rd_req || rd_addr != hold_addr)) hold_err++;
            if (rd_req && !rd_ack) begin
                if (wcnt >= lat) begin
                    grant = 1'b1;
                    rd_ack <= 1'b1;
                    rd_data <= vb(rd_addr);
                    if (nreads < 128) reads[nreads] = rd_addr;
                    nreads++;
                    wcnt = 0;
                end else wcnt++;
            end else rd_ack <= 1'b0;
            hold_pend = rd_req && !rd_ack && !grant;
            hold_addr = rd_addr;
        end
    end

    // Line-buffer capture and write-order monitor.
    always @(negedge clk) begin
        if (rst_n && lb_we) begin
            if (int'(lb_addr) != (nwr % 256)) order_err++;
            pix[lb_addr] = lb_data;
            nwr++;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Renders one line and checks fetches and pixels against the model.
    task automatic run_line(input string req, input int vc, input bit en,
                            input logic [7:0] col_reg, input logic [13:0] nb,
                            input logic [13:0] pb, input int latency, input bit disturb);
        bit act;
        int row, fine, guard;
        @(negedge clk);
        vcount = 9'(vc); disp_en = en; colours = col_reg;
        name_base = nb; pat_base = pb; lat = latency;
        nreads = 0; nwr = 0; order_err = 0; hold_err = 0;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        if (disturb) begin
            // R10: extra line_start mid-line with a different scanline
            repeat (60) @(negedge clk);
            vcount = 9'(vc + 37); disp_en = ~en;
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
        end
        guard = 0;
        while (nwr < 256 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (20) @(negedge clk);
        act = en && vc >= 16 && vc < 208;
        row = (vc - 16) / 8;
        fine = (vc - 16) % 8;
        check(req, "R8 write count", nwr, 256);
        check(req, "R8 write order errors", order_err, 0);
        check(req, "R9 hold errors", hold_err, 0);
        check(req, "R6/R7 read count", nreads, act ? 80 : 0);
        if (act && nreads == 80) begin
            for (int c = 0; c < 40; c++) begin
                logic [13:0] na, pa;
                na = 14'(int'(nb) + row * 40 + c);
                pa = 14'(int'(pb) + int'(vb(na)) * 8 + fine);
                check(req, "R2 name addr", reads[2*c], na);
                check(req, "R3 pattern addr", reads[2*c+1], pa);
            end
        end
        for (int x = 0; x < 256; x++) begin
            int e;
            if (x >= 240) e = 0;
            else if (!act) e = col_reg[3:0];
            else begin
                logic [13:0] na, pa;
                logic [7:0] p;
                na = 14'(int'(nb) + row * 40 + x / 6);
                pa = 14'(int'(pb) + int'(vb(na)) * 8 + fine);
                p = vb(pa);
                e = p[7 - (x % 6)] ? col_reg[7:4] : col_reg[3:0];
            end
            check(req, (x >= 240) ? "R5 edge pixel" : "R4 pixel", pix[x], e);
        end
    endtask

    task automatic t_reset();
        // R1: outputs quiet during and after reset
        repeat (3) @(negedge clk);
        check("R1", "rd_req in reset", rd_req, 0);
        check("R1", "lb_we in reset", lb_we, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "rd_req idle", rd_req, 0);
        check("R1", "lb_we idle", lb_we, 0);
    endtask

    task automatic t_first_row();
        seed = 3;
        run_line("R4", 16, 1'b1, 8'hF4, 14'h0000, 14'h0800, 0, 1'b0);
    endtask

    task automatic t_last_row();
        seed = 91;
        run_line("R7", 207, 1'b1, 8'h1E, 14'h3F80, 14'h3C00, 2, 1'b0);
    endtask

    task automatic t_mid_rows();
        seed = 57;
        run_line("R2", 100, 1'b1, 8'hA5, 14'h0400, 14'h2000, 1, 1'b0);
        seed = 200;
        run_line("R3", 131, 1'b1, 8'h3C, 14'h1234, 14'h3FF0, 3, 1'b0);
    endtask

    task automatic t_outside_window();
        seed = 11;
        run_line("R7", 15, 1'b1, 8'h72, 14'h0000, 14'h0800, 0, 1'b0);
        run_line("R7", 208, 1'b1, 8'h29, 14'h0000, 14'h0800, 1, 1'b0);
    endtask

    task automatic t_display_off();
        seed = 5;
        run_line("R6", 60, 1'b0, 8'h9B, 14'h0000, 14'h0800, 0, 1'b0);
    endtask

    task automatic t_busy_restart();
        seed = 77;
        run_line("R10", 40, 1'b1, 8'hD6, 14'h0100, 14'h1800, 1, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_first_row();
        t_last_row();
        t_mid_rows();
        t_outside_window();
        t_display_off();
        t_busy_restart();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule